// File: doc/BRIEF.md
# Buck Regulator Fault Supervisor

This block is the digital supervisor of a synchronous buck converter. Every clock it samples the flags from the analog comparators: the high-side current-limit compare, and four output-level windows (above 106 %, above 130 %, below 94 % and below 65 % of nominal) plus an at-nominal flag. It also samples the high-side gate state, the enable input and two supply-good inputs. From these it raises requests that the PWM and gate-drive logic obeys. It can latch the converter off, force the high side off and the low side on to bleed off a mild overvoltage, or ask the light-load controller to return to full switching frequency.

Overcurrent is only trusted once a blanking interval has passed after the high-side gate turns on. Hard faults must persist on consecutive clocks before they latch. The non-latching overvoltage discharge and the frequency boost each hold until the output is back at nominal. A latched fault holds both switches off until the enable or one of the supply-good inputs drops low. A status vector records which faults latched, and a single shutdown output is asserted for all of them.

Top module: `fault_supervisor`

## Requirements
- R1: An overcurrent sample counts only while `hs_gate_i` is high and at least BLANK_CYC clock edges have passed since the first edge at which the gate was seen high. BLANK_CYC is BLANK_NS/CLK_NS rounded up, which gives 15 at the defaults. Each new rise of the gate starts the interval again.
- R2: Overcurrent latches after FAULT_CYCLES (default 4) consecutive counted samples with `oc_cmp_i` high. It sets `fault_o` bit 0 and `shutdown_o` right after the last of those edges. A single edge without a counted sample restarts the count.
- R3: While any fault is latched, `shutdown_o`, `hs_off_o` and `ls_off_o` are high and `ls_on_o` and `freq_max_o` are low. This state holds whatever the level flags do, for as long as `en_i`, `vcc_good_i` and `vin_good_i` stay high.
- R4: When `ov_lo_i` (above 106 %) is sampled, `hs_off_o` and `ls_on_o` go high from the next cycle without latching a fault. They stay high until `at_nom_i` is sampled.
- R5: `ov_hi_i` (above 130 %) sampled high on FAULT_CYCLES consecutive edges latches overvoltage in `fault_o` bit 1. A shorter run latches nothing.
- R6: `uv_hi_i` (below 65 %) sampled high on FAULT_CYCLES consecutive edges latches undervoltage in `fault_o` bit 2. This happens whatever the level of `psave_i`.
- R7: With `psave_i` high, a sampled `uv_lo_i` (below 94 %) raises `freq_max_o` from the next cycle. It holds until `at_nom_i` is sampled or `psave_i` falls. With `psave_i` low, `uv_lo_i` has no effect.
- R8: An edge with any of `en_i`, `vcc_good_i` or `vin_good_i` low clears `fault_o`, every persistence count, the discharge and the boost. No fault is evaluated while any of them is low.
- R9: Faults that qualify on the same edge each set their own status bit, and one common `shutdown_o` is asserted.
- R10: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| vcc_good_i | input | 1 | Control supply good |
| vin_good_i | input | 1 | Input supply good |
| psave_i | input | 1 | Standby power-saving mode active |
| hs_gate_i | input | 1 | High-side gate drive state |
| oc_cmp_i | input | 1 | High-side current above limit |
| ov_lo_i | input | 1 | Output above 106 % of nominal |
| ov_hi_i | input | 1 | Output above 130 % of nominal |
| uv_lo_i | input | 1 | Output below 94 % of nominal |
| uv_hi_i | input | 1 | Output below 65 % of nominal |
| at_nom_i | input | 1 | Output back at nominal |
| shutdown_o | output | 1 | Latched-off request |
| hs_off_o | output | 1 | Force high side off |
| ls_off_o | output | 1 | Force low side off |
| ls_on_o | output | 1 | Force low side on |
| freq_max_o | output | 1 | Raise switching frequency to maximum |
| fault_o | output | 3 | Latched faults: bit 0 overcurrent, bit 1 overvoltage, bit 2 undervoltage |

## Verification
Discharge, boost and clearing requests appear one edge after the flag is sampled. A level fault appears right after the fourth consecutive sampling edge. An overcurrent appears after the nineteenth edge of a gate-high interval (15 blanking edges plus 4 counted samples). The bench drives inputs on falling edges and counts whole clock periods to exactly those edges. It checks one edge early that nothing has yet changed and checks again at the due edge. Runs that fall one sample short of a threshold are also checked, both at the threshold edge and several cycles later.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int unsigned NUM_FLT = 3;
  localparam int unsigned FLT_OC  = 0;
  localparam int unsigned FLT_OV  = 1;
  localparam int unsigned FLT_UV  = 2;

  typedef logic [NUM_FLT-1:0] flt_vec_t;
endpackage

// File: rtl/fsup_blank.sv
module fsup_blank #(
  parameter int unsigned BLANK_CYC = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic open_o
);
  localparam int unsigned CW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);

  logic [CW-1:0] cnt_q;

  // count resets while gate is low, so every rise restarts the interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!gate_i)                  cnt_q <= '0;
    else if (cnt_q < CW'(BLANK_CYC))   cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = gate_i && (cnt_q >= CW'(BLANK_CYC));
endmodule

// File: rtl/fsup_persist.sv
module fsup_persist #(
  parameter int unsigned N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cond_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || !cond_i) cnt_q <= '0;
    else if (cnt_q < CW'(N))  cnt_q <= cnt_q + 1'b1;
  end

  // true on the N-th consecutive sampled edge
  assign hit_o = cond_i && !clr_i && (cnt_q >= CW'(N - 1));
endmodule

// File: rtl/fsup_corrective.sv
module fsup_corrective (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic faulted_i,
  input  logic psave_i,
  input  logic ov_lo_i,
  input  logic uv_lo_i,
  input  logic at_nom_i,
  output logic disch_o,
  output logic boost_o
);
  logic disch_q, boost_q;
  logic live;

  assign live = armed_i && !faulted_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                disch_q <= 1'b0;
    else if (!live)             disch_q <= 1'b0;
    else if (ov_lo_i)           disch_q <= 1'b1;
    else if (at_nom_i)          disch_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 boost_q <= 1'b0;
    else if (!live || !psave_i)  boost_q <= 1'b0;
    else if (uv_lo_i)            boost_q <= 1'b1;
    else if (at_nom_i)           boost_q <= 1'b0;
  end

  assign disch_o = disch_q;
  assign boost_o = boost_q;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned CLK_NS       = 10,
  parameter int unsigned BLANK_NS     = 150,
  parameter int unsigned FAULT_CYCLES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               vcc_good_i,
  input  logic               vin_good_i,
  input  logic               psave_i,
  input  logic               hs_gate_i,
  input  logic               oc_cmp_i,
  input  logic               ov_lo_i,
  input  logic               ov_hi_i,
  input  logic               uv_lo_i,
  input  logic               uv_hi_i,
  input  logic               at_nom_i,
  output logic               shutdown_o,
  output logic               hs_off_o,
  output logic               ls_off_o,
  output logic               ls_on_o,
  output logic               freq_max_o,
  output logic [NUM_FLT-1:0] fault_o
);
  localparam int unsigned BLANK_CYC = (BLANK_NS + CLK_NS - 1) / CLK_NS;

  logic     armed, oc_open, faulted, disch, boost;
  flt_vec_t cond, hit, fault_q;

  assign armed = en_i && vcc_good_i && vin_good_i;

  fsup_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (hs_gate_i),
    .open_o (oc_open)
  );

  assign cond[FLT_OC] = oc_open && oc_cmp_i;
  assign cond[FLT_OV] = ov_hi_i;
  assign cond[FLT_UV] = uv_hi_i;

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    fsup_persist #(.N(FAULT_CYCLES)) u_persist (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!armed),
      .cond_i (cond[g]),
      .hit_o  (hit[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     fault_q[g] <= 1'b0;
      else if (!armed) fault_q[g] <= 1'b0;
      else if (hit[g]) fault_q[g] <= 1'b1;
    end
  end

  assign faulted = |fault_q;

  fsup_corrective u_corr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .armed_i   (armed),
    .faulted_i (faulted),
    .psave_i   (psave_i),
    .ov_lo_i   (ov_lo_i),
    .uv_lo_i   (uv_lo_i),
    .at_nom_i  (at_nom_i),
    .disch_o   (disch),
    .boost_o   (boost)
  );

  assign shutdown_o = faulted;
  assign hs_off_o   = faulted || disch;
  assign ls_off_o   = faulted;
  assign ls_on_o    = disch && !faulted;
  assign freq_max_o = boost && !faulted;
  assign fault_o    = fault_q;
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk
  import fsup_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               vcc_good_i,
  input logic               vin_good_i,
  input logic               psave_i,
  input logic               hs_gate_i,
  input logic               oc_cmp_i,
  input logic               ov_lo_i,
  input logic               ov_hi_i,
  input logic               uv_lo_i,
  input logic               uv_hi_i,
  input logic               at_nom_i,
  input logic               shutdown_o,
  input logic               hs_off_o,
  input logic               ls_off_o,
  input logic               ls_on_o,
  input logic               freq_max_o,
  input logic [NUM_FLT-1:0] fault_o
);
  logic armed;
  assign armed = en_i && vcc_good_i && vin_good_i;

  assert_oc_needs_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o[FLT_OC]) |-> $past(hs_gate_i) && $past(oc_cmp_i));

  assert_ov_needs_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o[FLT_OV]) |-> $past(ov_hi_i) && $past(armed));

  assert_uv_needs_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o[FLT_UV]) |-> $past(uv_hi_i) && $past(armed));

  assert_off_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> hs_off_o && ls_off_o && !ls_on_o && !freq_max_o);

  assert_latch_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o && armed |=> shutdown_o);

  assert_discharge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_lo_i && armed && !shutdown_o |=> hs_off_o && (ls_on_o || shutdown_o));

  assert_boost_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psave_i && uv_lo_i && armed && !shutdown_o |=> freq_max_o || shutdown_o);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> fault_o == '0 && !shutdown_o && !ls_on_o && !freq_max_o);
endmodule

bind fault_supervisor fault_supervisor_chk u_chk (.*);

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i, vcc_good_i, vin_good_i, psave_i, hs_gate_i, oc_cmp_i;
  logic ov_lo_i, ov_hi_i, uv_lo_i, uv_hi_i, at_nom_i;
  logic shutdown_o, hs_off_o, ls_off_o, ls_on_o, freq_max_o;
  logic [2:0] fault_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_supervisor u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .vcc_good_i(vcc_good_i),
    .vin_good_i(vin_good_i), .psave_i(psave_i), .hs_gate_i(hs_gate_i),
    .oc_cmp_i(oc_cmp_i), .ov_lo_i(ov_lo_i), .ov_hi_i(ov_hi_i),
    .uv_lo_i(uv_lo_i), .uv_hi_i(uv_hi_i), .at_nom_i(at_nom_i),
    .shutdown_o(shutdown_o), .hs_off_o(hs_off_o), .ls_off_o(ls_off_o),
    .ls_on_o(ls_on_o), .freq_max_o(freq_max_o), .fault_o(fault_o)
  );

  // {shutdown, hs_off, ls_off, ls_on, freq_max}
  function automatic logic [4:0] outs();
    return {shutdown_o, hs_off_o, ls_off_o, ls_on_o, freq_max_o};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    hs_gate_i = 0; oc_cmp_i = 0; ov_lo_i = 0; ov_hi_i = 0;
    uv_lo_i = 0; uv_hi_i = 0; at_nom_i = 0; psave_i = 0;
  endtask

  task automatic rearm_en();
    quiet();
    en_i = 0; cyc(1);
    check("R8", "cleared by enable", {3'b0, outs()}, 8'h00);
    check("R8", "status cleared", {5'b0, fault_o}, 8'h00);
    en_i = 1; cyc(1);
  endtask

  task automatic t_reset();
    check("R10", "outputs in reset", {fault_o, outs()}, 8'h00);
    rst_ni = 1; cyc(2);
    check("R10", "outputs after reset", {fault_o, outs()}, 8'h00);
  endtask

  task automatic t_oc_basic();
    hs_gate_i = 1; oc_cmp_i = 1;
    cyc(18);
    check("R2", "no oc before 19th edge", {7'b0, shutdown_o}, 8'h00);
    cyc(1);
    check("R2", "oc status", {5'b0, fault_o}, 8'h01);
    check("R3", "off outputs", {3'b0, outs()}, 8'b0001_1100);
    hs_gate_i = 0; oc_cmp_i = 0; ov_lo_i = 1; psave_i = 1; uv_lo_i = 1;
    cyc(5);
    check("R3", "held off despite flags", {3'b0, outs()}, 8'b0001_1100);
    rearm_en();
  endtask

  task automatic t_oc_blank();
    for (int k = 0; k < 3; k++) begin
      hs_gate_i = 1; oc_cmp_i = 1; cyc(15);
      hs_gate_i = 0; cyc(1);
    end
    check("R1", "oc blanked on each rise", {5'b0, fault_o}, 8'h00);
    // gap restart
    hs_gate_i = 1; cyc(18);
    oc_cmp_i = 0; cyc(1);
    oc_cmp_i = 1; cyc(3);
    check("R2", "gap restarts oc count", {5'b0, fault_o}, 8'h00);
    cyc(1);
    check("R2", "oc after restarted run", {5'b0, fault_o}, 8'h01);
    rearm_en();
  endtask

  task automatic t_discharge();
    ov_lo_i = 1; cyc(1);
    check("R4", "discharge on", {3'b0, outs()}, 8'b0000_1010);
    ov_lo_i = 0; cyc(3);
    check("R4", "discharge held", {3'b0, outs()}, 8'b0000_1010);
    at_nom_i = 1; cyc(1);
    check("R4", "released at nominal", {fault_o, outs()}, 8'h00);
    at_nom_i = 0;
  endtask

  task automatic t_ov();
    ov_hi_i = 1; cyc(3); ov_hi_i = 0; cyc(1);
    ov_hi_i = 1; cyc(3); ov_hi_i = 0; cyc(4);
    check("R5", "short ov runs ignored", {5'b0, fault_o}, 8'h00);
    ov_lo_i = 1; ov_hi_i = 1; cyc(3);
    check("R5", "no ov latch at 3", {7'b0, shutdown_o}, 8'h00);
    cyc(1);
    check("R5", "ov latched", {5'b0, fault_o}, 8'h02);
    check("R3", "ov off outputs", {3'b0, outs()}, 8'b0001_1100);
    quiet(); vcc_good_i = 0; cyc(1);
    check("R8", "cleared by vcc_good", {fault_o, outs()}, 8'h00);
    vcc_good_i = 1; cyc(1);
  endtask

  task automatic t_uv();
    uv_hi_i = 1; cyc(3);
    check("R6", "no uv latch at 3", {5'b0, fault_o}, 8'h00);
    cyc(1);
    check("R6", "uv latched, psave low", {5'b0, fault_o}, 8'h04);
    quiet(); vin_good_i = 0; cyc(1);
    check("R8", "cleared by vin_good", {fault_o, outs()}, 8'h00);
    vin_good_i = 1; cyc(1);
  endtask

  task automatic t_boost();
    uv_lo_i = 1; cyc(2);
    check("R7", "no boost without psave", {7'b0, freq_max_o}, 8'h00);
    psave_i = 1; cyc(1);
    check("R7", "boost on", {3'b0, outs()}, 8'h01);
    uv_lo_i = 0; cyc(3);
    check("R7", "boost held", {7'b0, freq_max_o}, 8'h01);
    at_nom_i = 1; cyc(1);
    check("R7", "boost released at nominal", {7'b0, freq_max_o}, 8'h00);
    at_nom_i = 0; uv_lo_i = 1; cyc(1);
    psave_i = 0; cyc(1);
    check("R7", "boost dropped with psave", {7'b0, freq_max_o}, 8'h00);
    quiet();
  endtask

  task automatic t_both();
    psave_i = 1; ov_hi_i = 1; uv_hi_i = 1; cyc(4);
    check("R9", "two faults, one shutdown", {fault_o, outs()}, {3'b110, 5'b11100});
    rearm_en();
  endtask

  task automatic t_disarmed();
    en_i = 0; ov_hi_i = 1; cyc(6);
    check("R8", "no fault while disabled", {5'b0, fault_o}, 8'h00);
    en_i = 1; cyc(3);
    check("R8", "count restarts on enable", {5'b0, fault_o}, 8'h00);
    cyc(1);
    check("R5", "ov latched after enable", {5'b0, fault_o}, 8'h02);
    rearm_en();
  endtask

  initial begin
    quiet(); en_i = 1; vcc_good_i = 1; vin_good_i = 1;
    cyc(2);
    t_reset();
    t_oc_basic();
    t_oc_blank();
    t_discharge();
    t_ov();
    t_uv();
    t_boost();
    t_both();
    t_disarmed();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule